// File: doc/BRIEF.md
# Key-Guarded Error-Handling Configuration Register

This block is a small register-file slice that holds the configuration for non-correctable memory-error handling behind a two-key write guard. One key is a write-enable bit in a separate key-control register. The other key is a lock bit that sits in the guarded register itself.

The guarded register is open only while the write-enable bit is 1 and the lock bit is 0. While it is open, software may change its fields. Either key on its own closes it again.

The guarded register stores four control fields and exports them as outputs:

- an enable for freezing on a non-correctable error;
- an interrupt enable for host-side accesses;
- an interrupt enable for fabric-side accesses;
- an ECC-disable bit.

The ECC-disable bit is independent of the other three fields. Software can therefore turn off freezing and interrupts while correction of correctable errors stays on.

A plain register bus reaches both registers. The bus has an address, write data and a write strobe, and returns read data. Address map: the key-control register is at 0x4 and the guarded register is at 0x8.

Top module: `guarded_cfg_lock`

## Requirements
- R1: After reset, the cfg_open output is 0. The key-control register reads 0x00000000. The guarded register reads 0x8000000E: lock bit 31 set, fabric enable (bit 3), host enable (bit 2) and freeze enable (bit 1) set, ECC-disable (bit 0) clear.
- R2: Opening takes two writes in order: first a write of bit 0 = 1 to the key-control register at 0x4, then a write to the guarded register at 0x8 with bit 31 = 0. After the second write, cfg_open is 1.
- R3: When the write-enable bit is 0, a write to the guarded register with bit 31 = 0 leaves the lock bit set and all fields unchanged.
- R4: Fields take the written bits [3:0] only from a write made while the register is already open with bit 31 = 0. The opening write itself changes no field.
- R5: A write to the guarded register with bit 31 = 1 sets the lock bit, clears cfg_open and changes no field, whatever the state of the keys.
- R6: Writing 0 to key-control bit 0 clears cfg_open, and later field writes are dropped. If the lock bit is still 0, writing 1 to key-control bit 0 again reopens the register.
- R7: Reads are combinational and return the current contents in any lock state. Key-control bit 0 is the write-enable bit. The guarded register returns lock bit 31 and fields [3:0]. All other bits, and all unmapped addresses, read 0.
- R8: The ecc_disable output changes only by its own field bit 0. Clearing the freeze and interrupt enables leaves it as it was.
- R9: cfg_open is 1 exactly when the write-enable bit is 1 and the lock bit is 0.
- R10: A write takes effect at the clock edge that samples it. Read data and outputs show the old value until that edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| ncf_freeze_en | output | 1 | Freeze-on-non-correctable-error enable |
| ncf_host_irq_en | output | 1 | Host-access non-correctable-error interrupt enable |
| ncf_fabric_irq_en | output | 1 | Fabric-access non-correctable-error interrupt enable |
| ecc_disable | output | 1 | ECC-disable control |
| cfg_open | output | 1 | High while both keys are open |

## Verification
Every write changes state at the rising edge that samples it. The outputs and the read data, which are decoded combinationally from that state, therefore show the result one cycle after the strobe is driven.

The bench drives each write on a falling edge and removes the strobe on the next falling edge. It then samples outputs and read-back at that falling edge, half a cycle after the update. One directed case also samples before the edge to confirm that the old value still holds.

The sweep covers every combination of the two keys, all sixteen field patterns and both values of bit 31. For each case, the expected contents are computed from the stated key rules.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
    localparam int FIELD_W = 4;
    localparam int WEN_POS = 0;

    typedef struct packed {
        logic fabric_irq_en;
        logic host_irq_en;
        logic freeze_en;
        logic ecc_dis;
    } cfg_fields_t;

    typedef struct packed {
        logic wen;
        logic lock;
    } key_state_t;
endpackage

// File: rtl/gcl_key_tracker.sv
module gcl_key_tracker
    import gcl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic key_wen_bit,
    input  logic cfg_wr,
    input  logic lock_req,
    output logic wen,
    output logic lock,
    output logic open
);
    key_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (key_wr) begin
            s_d.wen = key_wen_bit;
        end
        if (cfg_wr) begin
            if (lock_req) begin
                s_d.lock = 1'b1;
            end else if (s_q.wen) begin
                s_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{wen: 1'b0, lock: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign wen  = s_q.wen;
    assign lock = s_q.lock;
    assign open = s_q.wen & ~s_q.lock;
endmodule

// File: rtl/gcl_field_store.sv
module gcl_field_store
    import gcl_pkg::*;
#(
    parameter logic [FIELD_W-1:0] FIELD_RST = 4'b1110
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        open,
    input  logic        lock_req,
    input  cfg_fields_t new_fields,
    output cfg_fields_t fields
);
    cfg_fields_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (cfg_wr && open && !lock_req) begin
            f_d = new_fields;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= cfg_fields_t'(FIELD_RST);
        end else begin
            f_q <= f_d;
        end
    end

    assign fields = f_q;
endmodule

// File: rtl/gcl_read_mux.sv
module gcl_read_mux
    import gcl_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int          DATA_W   = 32,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 4'h4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 4'h8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    input  logic              lock,
    input  cfg_fields_t       fields,
    output logic [DATA_W-1:0] rdata
);
    localparam int LOCK_POS = DATA_W - 1;

    logic [DATA_W-1:0] cfg_word;
    logic [DATA_W-1:0] key_word;
    logic [FIELD_W-1:0] field_bits;

    assign field_bits = fields;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b < FIELD_W) begin : g_field
            assign cfg_word[b] = field_bits[b];
        end else if (b == LOCK_POS) begin : g_lock
            assign cfg_word[b] = lock;
        end else begin : g_zero
            assign cfg_word[b] = 1'b0;
        end
        if (b == WEN_POS) begin : g_wen
            assign key_word[b] = wen;
        end else begin : g_kzero
            assign key_word[b] = 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == KEY_ADDR) begin
            rdata = key_word;
        end else if (addr == CFG_ADDR) begin
            rdata = cfg_word;
        end
    end
endmodule

// File: rtl/guarded_cfg_lock.sv
module guarded_cfg_lock
    import gcl_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int          DATA_W   = 32,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 4'h4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 4'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ncf_freeze_en,
    output logic              ncf_host_irq_en,
    output logic              ncf_fabric_irq_en,
    output logic              ecc_disable,
    output logic              cfg_open
);
    localparam int LOCK_POS = DATA_W - 1;

    logic        key_wr, cfg_wr, lock_req;
    logic        wen, lock, open;
    cfg_fields_t fields;
    logic        unused_wdata_bits;

    assign key_wr   = bus_wr && (bus_addr == KEY_ADDR);
    assign cfg_wr   = bus_wr && (bus_addr == CFG_ADDR);
    assign lock_req = bus_wdata[LOCK_POS];
    assign unused_wdata_bits = ^bus_wdata[LOCK_POS-1:FIELD_W];

    gcl_key_tracker u_keys (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_wr      (key_wr),
        .key_wen_bit (bus_wdata[WEN_POS]),
        .cfg_wr      (cfg_wr),
        .lock_req    (lock_req),
        .wen         (wen),
        .lock        (lock),
        .open        (open)
    );

    gcl_field_store u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .open       (open),
        .lock_req   (lock_req),
        .new_fields (cfg_fields_t'(bus_wdata[FIELD_W-1:0])),
        .fields     (fields)
    );

    gcl_read_mux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .KEY_ADDR (KEY_ADDR),
        .CFG_ADDR (CFG_ADDR)
    ) u_rd (
        .addr   (bus_addr),
        .wen    (wen),
        .lock   (lock),
        .fields (fields),
        .rdata  (bus_rdata)
    );

    assign ncf_freeze_en     = fields.freeze_en;
    assign ncf_host_irq_en   = fields.host_irq_en;
    assign ncf_fabric_irq_en = fields.fabric_irq_en;
    assign ecc_disable       = fields.ecc_dis;
    assign cfg_open          = open;
endmodule

// File: rtl/guarded_cfg_lock_chk.sv
module guarded_cfg_lock_chk #(
    parameter int          ADDR_W   = 4,
    parameter int          DATA_W   = 32,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 4'h4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 4'h8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ncf_freeze_en,
    input logic              ncf_host_irq_en,
    input logic              ncf_fabric_irq_en,
    input logic              ecc_disable,
    input logic              cfg_open
);
    logic       cfg_wr, key_wr;
    logic [3:0] outs;

    assign cfg_wr = bus_wr && (bus_addr == CFG_ADDR);
    assign key_wr = bus_wr && (bus_addr == KEY_ADDR);
    assign outs   = {ncf_fabric_irq_en, ncf_host_irq_en, ncf_freeze_en, ecc_disable};

    p_fields_need_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(outs) |-> $past(cfg_wr && cfg_open && !bus_wdata[DATA_W-1]));

    p_open_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(bus_wr));

    p_lock_bit_relocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && bus_wdata[DATA_W-1]) |=> !cfg_open);

    p_wen_clear_relocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !bus_wdata[0]) |=> !cfg_open);

    p_ecc_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(ecc_disable));

    p_status_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_addr == KEY_ADDR) |-> bus_rdata[0]);

    p_status_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_addr == CFG_ADDR) |-> !bus_rdata[DATA_W-1]);
endmodule

bind guarded_cfg_lock guarded_cfg_lock_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .KEY_ADDR (KEY_ADDR),
    .CFG_ADDR (CFG_ADDR)
) chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .bus_addr          (bus_addr),
    .bus_wdata         (bus_wdata),
    .bus_wr            (bus_wr),
    .bus_rdata         (bus_rdata),
    .ncf_freeze_en     (ncf_freeze_en),
    .ncf_host_irq_en   (ncf_host_irq_en),
    .ncf_fabric_irq_en (ncf_fabric_irq_en),
    .ecc_disable       (ecc_disable),
    .cfg_open          (cfg_open)
);

// File: tb/guarded_cfg_lock_tb_top.sv
module guarded_cfg_lock_tb_top;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam logic [3:0] KEY_A = 4'h4;
    localparam logic [3:0] CFG_A = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_rdata;
    logic        frz, hst, fab, eccd, opn;

    always #10 clk = ~clk;

    guarded_cfg_lock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_A), .CFG_ADDR(CFG_A)) dut_i (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_wr (bus_wr), .bus_rdata (bus_rdata), .ncf_freeze_en (frz),
        .ncf_host_irq_en (hst), .ncf_fabric_irq_en (fab), .ecc_disable (eccd),
        .cfg_open (opn)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit       m_wen;
    bit       m_lock;
    bit [3:0] m_f;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        if (a == KEY_A) begin
            m_wen = d[0];
        end else if (a == CFG_A) begin
            if (m_wen && !m_lock && !d[31]) m_f = d[3:0];
            if (d[31]) m_lock = 1'b1;
            else if (m_wen) m_lock = 1'b0;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        chk(tag, {27'b0, opn, fab, hst, frz, eccd}, {27'b0, m_wen & ~m_lock, m_f});
        chk("R9 status", {31'b0, opn}, {31'b0, m_wen & ~m_lock});
        rd(CFG_A, v);
        chk("R7 guarded readback", v, {m_lock, 27'b0, m_f});
        rd(KEY_A, v);
        chk("R7 key readback", v, {31'b0, m_wen});
    endtask

    task automatic set_state(input bit w, input bit l, input logic [3:0] base);
        wr(KEY_A, 32'h1);
        wr(CFG_A, {28'b0, base});
        wr(CFG_A, {28'b0, base});
        if (l) wr(CFG_A, 32'h8000_0000 | {28'b0, base});
        wr(KEY_A, {31'b0, w});
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        m_wen  = 1'b0;
        m_lock = 1'b1;
        m_f    = 4'b1110;
        @(negedge clk);
        check_all("R1 reset");
        rd(CFG_A, v);
        chk("R1 reset word", v, 32'h8000_000E);

        // R10: old value before the edge, new value after
        @(negedge clk);
        bus_addr  = KEY_A;
        bus_wdata = 32'h1;
        bus_wr    = 1'b1;
        #1;
        chk("R10 before edge", bus_rdata, 32'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(KEY_A, 32'h1);
        #1;
        chk("R10 after edge", bus_rdata, 32'h1);

        // R2: opening write after the key, then R8 independence
        wr(CFG_A, 32'h0);
        check_all("R2 open");
        wr(CFG_A, 32'h1);
        chk("R8 ecc set, others clear", {28'b0, fab, hst, frz, eccd}, 32'h1);
        wr(CFG_A, 32'h0);
        wr(CFG_A, 32'hE);
        chk("R8 enables set, ecc stays clear", {31'b0, eccd}, 32'h0);
        wr(CFG_A, 32'h1);
        wr(CFG_A, 32'h1);
        chk("R8 enables cleared, ecc kept", {28'b0, fab, hst, frz, eccd}, 32'h1);

        // R6: reopen after write-enable toggle while lock bit clear
        wr(KEY_A, 32'h0);
        check_all("R6 closed by key");
        wr(KEY_A, 32'h1);
        check_all("R6 reopened");

        // R7: unmapped addresses
        rd(4'h0, v);
        chk("R7 unmapped 0x0", v, 32'h0);
        rd(4'hC, v);
        chk("R7 unmapped 0xC", v, 32'h0);

        // Sweep: every key state, field pattern and bit 31 value
        for (int st = 0; st < 4; st++) begin
            for (int p = 0; p < 32; p++) begin
                bit w, l, b31;
                string tag;
                w   = st[1];
                l   = st[0];
                b31 = p[4];
                set_state(w, l, ~p[3:0]);
                if (b31) tag = "R5 relock write";
                else if (!w && l) tag = "R3 no key";
                else if (!w) tag = "R6 key cleared";
                else if (l) tag = "R2/R4 opening write";
                else tag = "R4 field write";
                wr(CFG_A, {b31, 27'b0, p[3:0]});
                check_all(tag);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule